// File: doc/BRIEF.md
# Store Queue Writeback Tracker

This block is a circular store queue that follows each store from allocation to release. Dispatch allocates an entry at the tail and is handed its slot index. The execute stage later fills in the address, the size and the data bytes of that slot. Commit, given a sequence number, marks every older store as committed and eligible to write back.

A writeback pointer walks from the head toward the tail. It offers the oldest eligible, not yet completed store to memory through a valid/accept handshake. If memory turns an offer down, the store path blocks until a retry input clears it. An entry is released, and the head moves on, only when memory reports that its write has completed; commit alone never frees a slot.

A squash, given a sequence number, removes every uncommitted store younger than it and pulls the tail back. One slot always stays empty as a sentinel, so the usable capacity is the depth minus one. The block also reports how many committed stores still wait to be written back.

Top module: `stq_tracker`

## Requirements
- R1: After reset the queue is empty: free count equals DEPTH-1, full is low, the pending count is 0, the pending flag is low, the writeback offer is low and the allocation index is 0.
- R2: An allocation takes the slot shown on the allocation index, which then advances by one modulo DEPTH. Full rises when DEPTH-1 stores are held. An allocation while full is ignored: neither the index nor the free count changes.
- R3: A write to a held slot records its address, size and data. The writeback outputs present exactly those values, together with the slot index and the store's sequence number, when that slot is offered.
- R4: A commit with sequence number C marks every held, uncommitted store whose sequence number is below C, compared as unsigned values. The pending count rises by the number of stores so marked.
- R5: The writeback offer is high only when the slot at the writeback pointer holds a committed, not completed store and the store path is not blocked. An uncommitted store is never offered.
- R6: An accepted offer moves the writeback pointer to the next slot in allocation order and lowers the pending count by one. Without an offer, the accept input has no effect.
- R7: An offer that is not accepted in its cycle blocks the store path, so the offer drops from the next cycle on. A retry pulse clears the block, and the same slot is offered again.
- R8: Commit and writeback acceptance never change the free count. A slot is released only when it is at the head and completed, at most one slot per cycle, one cycle after its completion is reported. Completions may arrive out of order, but release follows allocation order.
- R9: A squash with sequence number S removes every uncommitted store whose sequence number is above S. The free count grows by the number removed, and the allocation index moves back by that number.
- R10: In a cycle with a squash, any allocation and any commit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate one store at the tail |
| alloc_seq_i | input | SEQ_W | Sequence number of the allocated store |
| alloc_idx_o | output | PTR_W | Slot the next allocation takes |
| full_o | output | 1 | DEPTH-1 stores are held |
| free_o | output | CNT_W | Number of slots still available |
| wr_valid_i | input | 1 | Record address, size and data into a slot |
| wr_idx_i | input | PTR_W | Slot to be written |
| wr_addr_i | input | ADDR_W | Store address |
| wr_size_i | input | SIZE_W | Store size in bytes |
| wr_data_i | input | DATA_W | Store data bytes |
| commit_valid_i | input | 1 | Commit stores older than commit_seq_i |
| commit_seq_i | input | SEQ_W | Commit boundary sequence number |
| squash_valid_i | input | 1 | Remove stores younger than squash_seq_i |
| squash_seq_i | input | SEQ_W | Squash boundary sequence number |
| wb_valid_o | output | 1 | A store is offered to memory this cycle |
| wb_idx_o | output | PTR_W | Slot of the offered store |
| wb_seq_o | output | SEQ_W | Sequence number of the offered store |
| wb_addr_o | output | ADDR_W | Address of the offered store |
| wb_size_o | output | SIZE_W | Size of the offered store |
| wb_data_o | output | DATA_W | Data of the offered store |
| wb_accept_i | input | 1 | Memory takes the offered store |
| retry_i | input | 1 | Memory can accept again; clears the block |
| done_valid_i | input | 1 | Memory finished writing one store |
| done_idx_i | input | PTR_W | Slot whose write finished |
| pend_cnt_o | output | CNT_W | Committed stores not yet accepted by memory |
| pend_any_o | output | 1 | Pending count is non-zero |

## Verification
The bench fills the queue to its sentinel limit and then tries one more allocation. A design without the sentinel would take the slot and let the tail catch the head. It completes stores out of order, so a design that frees slots at commit or on any completion shows a free count that rises too early. It refuses an offer and then retries, which shows a missing block (the offer stays up) or a skipped slot (a different index reappears). It pairs a squash with an allocation and a commit in one cycle, and removes stores at several boundaries, so a wrong tail rollback shows in the allocation index and free count. A wrong ordering of squash against the other inputs shows in the pending count.

// File: rtl/stq_pkg.sv
package stq_pkg;
    typedef struct packed {
        logic held;       // slot holds a live store
        logic wb_ok;      // eligible for writeback
        logic cmt;        // committed
        logic cpl;        // memory write finished
    } stq_flags_t;

    localparam stq_flags_t STQ_FLAGS_CLR = '{held: 1'b0, wb_ok: 1'b0, cmt: 1'b0, cpl: 1'b0};
endpackage

// File: rtl/stq_age_cmp.sv
module stq_age_cmp #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16
) (
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
    input  logic [DEPTH-1:0]            held_i,
    input  logic [SEQ_W-1:0]            ref_i,
    output logic [DEPTH-1:0]            older_o,
    output logic [DEPTH-1:0]            younger_o
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign older_o[g]   = held_i[g] && (seq_i[g] < ref_i);
        assign younger_o[g] = held_i[g] && (seq_i[g] > ref_i);
    end
endmodule

// File: rtl/stq_popcnt.sv
module stq_popcnt #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [DEPTH-1:0] vec_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            cnt_o = cnt_o + CNT_W'(vec_i[i]);
        end
    end
endmodule

// File: rtl/stq_wb_sel.sv
module stq_wb_sel
    import stq_pkg::*;
(
    input  stq_flags_t flags_i,
    input  logic       blocked_i,
    output logic       go_o
);
    assign go_o = flags_i.held && flags_i.wb_ok && !flags_i.cpl && !blocked_i;
endmodule

// File: rtl/stq_tracker.sv
module stq_tracker
    import stq_pkg::*;
#(
    parameter int DEPTH      = 8,    // power of two, one slot is the sentinel
    parameter int SEQ_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH) + 1,
    localparam int DATA_W = DATA_BYTES * 8,
    localparam int SIZE_W = $clog2(DATA_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    input  logic [SEQ_W-1:0]  alloc_seq_i,
    output logic [PTR_W-1:0]  alloc_idx_o,
    output logic              full_o,
    output logic [CNT_W-1:0]  free_o,
    input  logic              wr_valid_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [SIZE_W-1:0] wr_size_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              commit_valid_i,
    input  logic [SEQ_W-1:0]  commit_seq_i,
    input  logic              squash_valid_i,
    input  logic [SEQ_W-1:0]  squash_seq_i,
    output logic              wb_valid_o,
    output logic [PTR_W-1:0]  wb_idx_o,
    output logic [SEQ_W-1:0]  wb_seq_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    output logic [SIZE_W-1:0] wb_size_o,
    output logic [DATA_W-1:0] wb_data_o,
    input  logic              wb_accept_i,
    input  logic              retry_i,
    input  logic              done_valid_i,
    input  logic [PTR_W-1:0]  done_idx_i,
    output logic [CNT_W-1:0]  pend_cnt_o,
    output logic              pend_any_o
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0]                head;
        logic [PTR_W-1:0]                tail;
        logic [PTR_W-1:0]                wbp;
        logic [CNT_W-1:0]                count;
        logic [CNT_W-1:0]                pend;
        logic                            blocked;
        stq_flags_t [DEPTH-1:0]          flg;
        logic [DEPTH-1:0][SEQ_W-1:0]     seq;
        logic [DEPTH-1:0][ADDR_W-1:0]    addr;
        logic [DEPTH-1:0][SIZE_W-1:0]    size;
        logic [DEPTH-1:0][DATA_W-1:0]    data;
    } state_t;

    state_t s_q, s_d;

    logic [DEPTH-1:0] held_vec, cmt_vec;
    logic [DEPTH-1:0] cm_older, cm_younger_unused, sq_older_unused, sq_younger;
    logic [DEPTH-1:0] new_cmt, kill;
    logic [CNT_W-1:0] new_cmt_n, kill_n;
    logic             wb_go, head_rel, alloc_ok;

    for (genvar g = 0; g < DEPTH; g++) begin : g_vec
        assign held_vec[g] = s_q.flg[g].held;
        assign cmt_vec[g]  = s_q.flg[g].cmt;
    end

    stq_age_cmp #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) commit_cmp_i (
        .seq_i(s_q.seq), .held_i(held_vec), .ref_i(commit_seq_i),
        .older_o(cm_older), .younger_o(cm_younger_unused)
    );

    stq_age_cmp #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) squash_cmp_i (
        .seq_i(s_q.seq), .held_i(held_vec), .ref_i(squash_seq_i),
        .older_o(sq_older_unused), .younger_o(sq_younger)
    );

    assign new_cmt = cm_older & ~cmt_vec;
    assign kill    = sq_younger & ~cmt_vec;

    stq_popcnt #(.DEPTH(DEPTH)) cmt_cnt_i  (.vec_i(new_cmt), .cnt_o(new_cmt_n));
    stq_popcnt #(.DEPTH(DEPTH)) kill_cnt_i (.vec_i(kill),    .cnt_o(kill_n));

    stq_wb_sel wb_sel_i (
        .flags_i(s_q.flg[s_q.wbp]), .blocked_i(s_q.blocked), .go_o(wb_go)
    );

    assign head_rel = s_q.flg[s_q.head].held && s_q.flg[s_q.head].cpl;
    assign alloc_ok = alloc_valid_i && (s_q.count < CAP) && !squash_valid_i;

    always_comb begin
        s_d = s_q;
        // data / address write port
        if (wr_valid_i && s_q.flg[wr_idx_i].held) begin
            s_d.addr[wr_idx_i] = wr_addr_i;
            s_d.size[wr_idx_i] = wr_size_i;
            s_d.data[wr_idx_i] = wr_data_i;
        end
        // memory completion
        if (done_valid_i && s_q.flg[done_idx_i].held) begin
            s_d.flg[done_idx_i].cpl = 1'b1;
        end
        // writeback handshake
        if (wb_go) begin
            if (wb_accept_i) begin
                s_d.wbp  = s_q.wbp + PTR_W'(1);
                s_d.pend = s_d.pend - CNT_W'(1);
            end else begin
                s_d.blocked = 1'b1;
            end
        end
        if (retry_i) begin
            s_d.blocked = 1'b0;
        end
        if (squash_valid_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (kill[i]) s_d.flg[i] = STQ_FLAGS_CLR;
            end
            s_d.tail  = s_q.tail - PTR_W'(kill_n);
            s_d.count = s_d.count - kill_n;
        end else begin
            if (commit_valid_i) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (new_cmt[i]) begin
                        s_d.flg[i].cmt   = 1'b1;
                        s_d.flg[i].wb_ok = 1'b1;
                    end
                end
                s_d.pend = s_d.pend + new_cmt_n;
            end
            if (alloc_ok) begin
                s_d.flg[s_q.tail]      = STQ_FLAGS_CLR;
                s_d.flg[s_q.tail].held = 1'b1;
                s_d.seq[s_q.tail]      = alloc_seq_i;
                s_d.size[s_q.tail]     = '0;
                s_d.data[s_q.tail]     = '0;
                s_d.addr[s_q.tail]     = '0;
                s_d.tail               = s_q.tail + PTR_W'(1);
                s_d.count              = s_d.count + CNT_W'(1);
            end
        end
        // release the completed head
        if (head_rel) begin
            s_d.flg[s_q.head] = STQ_FLAGS_CLR;
            s_d.head          = s_q.head + PTR_W'(1);
            s_d.count         = s_d.count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_idx_o = s_q.tail;
    assign full_o      = (s_q.count >= CAP);
    assign free_o      = CAP - s_q.count;
    assign wb_valid_o  = wb_go;
    assign wb_idx_o    = s_q.wbp;
    assign wb_seq_o    = s_q.seq[s_q.wbp];
    assign wb_addr_o   = s_q.addr[s_q.wbp];
    assign wb_size_o   = s_q.size[s_q.wbp];
    assign wb_data_o   = s_q.data[s_q.wbp];
    assign pend_cnt_o  = s_q.pend;
    assign pend_any_o  = (s_q.pend != '0);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CAP);

    // R2
    full_alloc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && alloc_valid_i && !squash_valid_i |=> alloc_idx_o == $past(alloc_idx_o));

    // R6
    accept_drains_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o && wb_accept_i && !commit_valid_i |=> pend_cnt_o == $past(pend_cnt_o) - CNT_W'(1));

    // R7
    refuse_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o && !wb_accept_i && !retry_i |=> !wb_valid_o);

    // R8
    free_only_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !squash_valid_i && !head_rel |=> free_o <= $past(free_o));

    // R4
    pend_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt_o <= s_q.count);
endmodule

// File: tb/stq_tracker_tb_top.sv
module stq_tracker_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8;
    localparam int SEQ_W = 16;
    localparam int ADDR_W = 32;
    localparam int DATA_BYTES = 8;
    localparam int PTR_W = 3;
    localparam int CNT_W = 4;
    localparam int DATA_W = 64;
    localparam int SIZE_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid_i = 0, wr_valid_i = 0, commit_valid_i = 0, squash_valid_i = 0;
    logic wb_accept_i = 0, retry_i = 0, done_valid_i = 0;
    logic [SEQ_W-1:0] alloc_seq_i = '0, commit_seq_i = '0, squash_seq_i = '0, wb_seq_o;
    logic [PTR_W-1:0] alloc_idx_o, wr_idx_i = '0, wb_idx_o, done_idx_i = '0;
    logic [ADDR_W-1:0] wr_addr_i = '0, wb_addr_o;
    logic [SIZE_W-1:0] wr_size_i = '0, wb_size_o;
    logic [DATA_W-1:0] wr_data_i = '0, wb_data_o;
    logic [CNT_W-1:0] free_o, pend_cnt_o;
    logic full_o, wb_valid_o, pend_any_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    stq_tracker #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid_i), .alloc_seq_i(alloc_seq_i), .alloc_idx_o(alloc_idx_o),
        .full_o(full_o), .free_o(free_o),
        .wr_valid_i(wr_valid_i), .wr_idx_i(wr_idx_i), .wr_addr_i(wr_addr_i),
        .wr_size_i(wr_size_i), .wr_data_i(wr_data_i),
        .commit_valid_i(commit_valid_i), .commit_seq_i(commit_seq_i),
        .squash_valid_i(squash_valid_i), .squash_seq_i(squash_seq_i),
        .wb_valid_o(wb_valid_o), .wb_idx_o(wb_idx_o), .wb_seq_o(wb_seq_o),
        .wb_addr_o(wb_addr_o), .wb_size_o(wb_size_o), .wb_data_o(wb_data_o),
        .wb_accept_i(wb_accept_i), .retry_i(retry_i),
        .done_valid_i(done_valid_i), .done_idx_i(done_idx_i),
        .pend_cnt_o(pend_cnt_o), .pend_any_o(pend_any_o)
    );

    typedef struct packed {
        logic [1:0]  op;     // 0 alloc, 1 commit, 2 squash
        logic [15:0] seq;
        logic [3:0]  free;
        logic [3:0]  pend;
        logic [2:0]  tail;
        logic        wbv;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{2'd0, 16'd10, 4'd6, 4'd0, 3'd1, 1'b0},
        '{2'd0, 16'd20, 4'd5, 4'd0, 3'd2, 1'b0},
        '{2'd0, 16'd30, 4'd4, 4'd0, 3'd3, 1'b0},
        '{2'd0, 16'd40, 4'd3, 4'd0, 3'd4, 1'b0},
        '{2'd1, 16'd25, 4'd3, 4'd2, 3'd4, 1'b1},
        '{2'd2, 16'd30, 4'd4, 4'd2, 3'd3, 1'b0},
        '{2'd0, 16'd50, 4'd3, 4'd2, 3'd4, 1'b0},
        '{2'd1, 16'd31, 4'd3, 4'd3, 3'd4, 1'b0},
        '{2'd2, 16'd45, 4'd4, 4'd3, 3'd3, 1'b0}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        alloc_valid_i = 0; commit_valid_i = 0; squash_valid_i = 0;
        wr_valid_i = 0; retry_i = 0; done_valid_i = 0;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] a, input logic [3:0] sz, input logic [63:0] d);
        wr_valid_i = 1; wr_idx_i = idx; wr_addr_i = a; wr_size_i = sz; wr_data_i = d;
        step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 free", 64'(free_o), 64'd7);
        check("R1 full", 64'(full_o), 64'd0);
        check("R1 pend", 64'(pend_cnt_o), 64'd0);
        check("R1 pend_any", 64'(pend_any_o), 64'd0);
        check("R1 wb_valid", 64'(wb_valid_o), 64'd0);
        check("R1 alloc_idx", 64'(alloc_idx_o), 64'd0);

        // table walk: R2 R4 R5 R7 R9
        for (int k = 0; k < 9; k++) begin
            case (TBL[k].op)
                2'd0: begin alloc_valid_i = 1; alloc_seq_i = TBL[k].seq; end
                2'd1: begin commit_valid_i = 1; commit_seq_i = TBL[k].seq; end
                default: begin squash_valid_i = 1; squash_seq_i = TBL[k].seq; end
            endcase
            step();
            check($sformatf("R2/R9 free step %0d", k), 64'(free_o), 64'(TBL[k].free));
            check($sformatf("R4 pend step %0d", k), 64'(pend_cnt_o), 64'(TBL[k].pend));
            check($sformatf("R9 tail step %0d", k), 64'(alloc_idx_o), 64'(TBL[k].tail));
            check($sformatf("R5/R7 wb_valid step %0d", k), 64'(wb_valid_o), 64'(TBL[k].wbv));
        end

        // R3 record data into held slots 0..2 (seqs 10,20,30)
        wr(3'd0, 32'h100, 4'd8, 64'h1122_3344_5566_7788);
        wr(3'd1, 32'h108, 4'd4, 64'h0000_0000_AABB_CCDD);
        wr(3'd2, 32'h10C, 4'd2, 64'h0000_0000_0000_BEEF);
        check("R7 still blocked", 64'(wb_valid_o), 64'd0);
        retry_i = 1;
        step();
        check("R7 reoffer valid", 64'(wb_valid_o), 64'd1);
        check("R7 same slot", 64'(wb_idx_o), 64'd0);
        check("R3 seq", 64'(wb_seq_o), 64'd10);
        check("R3 addr", 64'(wb_addr_o), 64'h100);
        check("R3 size", 64'(wb_size_o), 64'd8);
        check("R3 data", 64'(wb_data_o), 64'h1122_3344_5566_7788);

        // R6 accept in order
        wb_accept_i = 1;
        step();
        check("R6 next slot", 64'(wb_idx_o), 64'd1);
        check("R6 pend", 64'(pend_cnt_o), 64'd2);
        check("R3 size slot1", 64'(wb_size_o), 64'd4);
        check("R8 free unchanged by accept", 64'(free_o), 64'd4);
        step();
        check("R6 slot2", 64'(wb_idx_o), 64'd2);
        check("R3 data slot2", 64'(wb_data_o), 64'h0000_0000_0000_BEEF);
        step();
        check("R6 drained offer", 64'(wb_valid_o), 64'd0);
        check("R6 pend zero", 64'(pend_cnt_o), 64'd0);
        check("R6 pend_any low", 64'(pend_any_o), 64'd0);
        step();   // accept without offer: no effect
        check("R6 accept no offer", 64'(wb_idx_o), 64'd3);
        wb_accept_i = 0;

        // R8 out-of-order completion
        done_valid_i = 1; done_idx_i = 3'd1;
        step();
        check("R8 non-head done", 64'(free_o), 64'd4);
        done_valid_i = 1; done_idx_i = 3'd0;
        step();
        check("R8 release lag", 64'(free_o), 64'd4);
        step();
        check("R8 head released", 64'(free_o), 64'd5);
        step();
        check("R8 second released", 64'(free_o), 64'd6);
        done_valid_i = 1; done_idx_i = 3'd2;
        step();
        step();
        check("R8 third released", 64'(free_o), 64'd7);

        // R2 fill to capacity from slot 3
        for (int k = 0; k < 7; k++) begin
            alloc_valid_i = 1; alloc_seq_i = 16'(100 + k);
            step();
        end
        check("R2 full", 64'(full_o), 64'd1);
        check("R2 free zero", 64'(free_o), 64'd0);
        check("R2 tail", 64'(alloc_idx_o), 64'd2);
        alloc_valid_i = 1; alloc_seq_i = 16'd107;
        step();
        check("R2 full alloc ignored idx", 64'(alloc_idx_o), 64'd2);
        check("R2 full alloc ignored free", 64'(free_o), 64'd0);

        // R10 squash beats commit
        squash_valid_i = 1; squash_seq_i = 16'd103;
        commit_valid_i = 1; commit_seq_i = 16'd200;
        step();
        check("R9 squash free", 64'(free_o), 64'd3);
        check("R9 squash tail", 64'(alloc_idx_o), 64'd7);
        check("R10 commit ignored", 64'(pend_cnt_o), 64'd0);
        // R10 squash beats alloc
        squash_valid_i = 1; squash_seq_i = 16'd150;
        alloc_valid_i = 1; alloc_seq_i = 16'd300;
        step();
        check("R10 alloc ignored free", 64'(free_o), 64'd3);
        check("R10 alloc ignored idx", 64'(alloc_idx_o), 64'd7);

        // R7 refusal then retry
        commit_valid_i = 1; commit_seq_i = 16'd102;
        step();
        check("R4 commit two", 64'(pend_cnt_o), 64'd2);
        check("R5 offer slot3", 64'(wb_valid_o), 64'd1);
        check("R5 offer idx", 64'(wb_idx_o), 64'd3);
        step();
        check("R7 refused drops", 64'(wb_valid_o), 64'd0);
        check("R7 pend kept", 64'(pend_cnt_o), 64'd2);
        retry_i = 1;
        step();
        check("R7 retry same slot", 64'(wb_idx_o), 64'd3);
        check("R7 retry seq", 64'(wb_seq_o), 64'd100);
        check("R7 retry valid", 64'(wb_valid_o), 64'd1);
        check("R5 uncommitted not offered", 64'(pend_any_o), 64'd1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule